// File: doc/BRIEF.md
# Monochrome Colour-Expansion Transparent Blitter

This block runs a raster copy whose source is a 1-bit-per-pixel bitmap. Each source bit becomes one destination pixel of 8, 16, 24 or 32 bits. The copy is transparent: only set bits produce a destination write, and that write carries a fixed foreground colour. Clear bits leave the destination untouched.

A 5-bit left-skip field suppresses leading output at the start of every scanline. In the 8, 16 and 32 bpp modes it counts pixels. In packed 24 bpp mode it counts destination bytes. In that mode the matching source offset can pass a whole source byte, so the block splits it into a whole-byte advance and a residual bit position.

The block reads the bitmap through a byte-wide read port with one cycle of latency. It writes pixels through a 32-bit byte-enabled port, one pixel per cycle.

Top module: `mono_expand_blitter`

## Requirements
- R1: After reset, `busy`, `done`, `srcRdEn` and `dstWrEn` are low.
- R2: The depth codes on `depthSel` are 0 = 8 bpp, 1 = 16 bpp, 2 = 24 bpp and 3 = 32 bpp, giving 1, 2, 3 and 4 bytes per pixel (bpp below). For codes 0, 1 and 3, `skipField[2:0]` gives the number of pixels suppressed per line and `skipField[4:3]` is ignored. The destination byte skip is that count times bpp, and the source starts at bit offset equal to that count with no whole-byte advance.
- R3: For code 2, `skipField[4:0]` is the destination byte skip. Let q be that value divided by 3, rounded down. Each line's source begins q[3] whole bytes past the line start, at bit offset q[2:0] within that byte.
- R4: Source bits are used MSB first. After bit 0 of a byte is used and pixels remain on the line, the next byte is fetched from the following source address. A read request on `srcRdEn` expects `srcRdData` to be valid on the next cycle, and requests never occur on two consecutive cycles.
- R5: When `invert` is high, each fetched source byte is complemented before use.
- R6: For a set source bit, `dstWrEn` is high for one cycle and `dstWrData` equals `fgColor`. `dstWrBe` covers the low bpp byte lanes, least significant byte at the pixel address. For a clear bit no write occurs.
- R7: Pixels of a line sit at destination byte offsets starting at the destination skip and stepping by bpp while the offset is below `widthBytes`. A line whose skip is not below `widthBytes` produces no writes. Consecutive lines start `srcPitch` and `dstPitch` bytes after the previous line starts, and exactly `heightLines` lines are processed.
- R8: `busy` rises the cycle after an accepted start. `busy` stays high until the last line is finished. Then `done` pulses high for exactly one cycle while `busy` is low. A height of 0 completes with no writes.
- R9: `start` is accepted only while both `busy` and `done` are low. Otherwise it is ignored, and the configuration captured at acceptance is used for the whole copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request |
| depthSel | input | 2 | Destination depth code |
| widthBytes | input | DIM_W | Line width in destination bytes |
| heightLines | input | LINE_W | Number of scanlines |
| srcBase | input | ADDR_W | Source bitmap start address |
| srcPitch | input | ADDR_W | Source line pitch in bytes |
| dstBase | input | ADDR_W | Destination start address |
| dstPitch | input | ADDR_W | Destination line pitch in bytes |
| fgColor | input | 32 | Foreground colour |
| invert | input | 1 | Complement source bits |
| skipField | input | 5 | Left-skip field |
| srcRdEn | output | 1 | Source read request |
| srcRdAddr | output | ADDR_W | Source read byte address |
| srcRdData | input | 8 | Source read data, valid one cycle after the request |
| dstWrEn | output | 1 | Destination pixel write |
| dstWrAddr | output | ADDR_W | Destination byte address of the pixel |
| dstWrData | output | 32 | Pixel data |
| dstWrBe | output | 4 | Byte enables, lane 0 at `dstWrAddr` |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume two things about the inputs: that `rstN` is applied before the first start, and that the bench's memory answers every read with valid data on the next cycle. They also take it that the configuration pins are free to change during a copy, because the block latches them. The stimulus respects this. The bench holds reset for several cycles, models the source memory with a strict one-cycle reply, and in one test deliberately rewrites the configuration pins and pulses `start` mid-copy. Widths, pitches and bases are chosen so that every line fits inside the modelled memories and no address wraps.

// File: rtl/blit_pkg.sv
package blit_pkg;
  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic accept;    // capture configuration, reset line state
    logic lineInit;  // set up the per-line pointers
    logic fetch;     // issue a source read
    logic load;      // capture the returned source byte
    logic pixel;     // process one destination pixel
    logic advLine;   // step to the next scanline
  } blitCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LINE, ST_FETCH, ST_LOAD, ST_PIX, ST_DONE
  } blitState_t;
endpackage

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 12,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  blitCtl_t          ctl,
  input  logic              busy,
  input  logic [1:0]        depthSel,
  input  logic [DIM_W-1:0]  widthBytes,
  input  logic [LINE_W-1:0] heightLines,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] srcPitch,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [ADDR_W-1:0] dstPitch,
  input  logic [31:0]       fgColor,
  input  logic              invert,
  input  logic [4:0]        skipField,
  output logic [ADDR_W-1:0] srcRdAddr,
  input  logic [7:0]        srcRdData,
  output logic              dstWrEn,
  output logic [ADDR_W-1:0] dstWrAddr,
  output logic [31:0]       dstWrData,
  output logic [3:0]        dstWrBe,
  output logic              linesDone,
  output logic              lineEmpty,
  output logic              lastPix,
  output logic              byteEnd
);
  localparam int X_W = DIM_W + 1;

  logic [1:0]        depthQ;
  logic [DIM_W-1:0]  widthQ;
  logic [LINE_W-1:0] heightQ, lineCnt;
  logic [ADDR_W-1:0] srcPitchQ, dstPitchQ, lineSrc, lineDst, srcPtr;
  logic [31:0]       fgQ;
  logic              invQ;
  logic [4:0]        skipQ;
  logic [X_W-1:0]    xPos;
  logic [2:0]        bitIdx;
  logic [7:0]        srcByte;

  // Derived per-copy geometry.
  logic [2:0] bpp;
  logic [4:0] dstSkip;
  logic [3:0] quot;
  logic [2:0] bitSkip;
  logic       byteSkip;
  logic [3:0] beMask;

  always_comb begin
    unique case (depthQ)
      2'd0: begin bpp = 3'd1; beMask = 4'b0001; end
      2'd1: begin bpp = 3'd2; beMask = 4'b0011; end
      2'd2: begin bpp = 3'd3; beMask = 4'b0111; end
      default: begin bpp = 3'd4; beMask = 4'b1111; end
    endcase
    quot = 4'(skipQ / 5'd3);
    if (depthQ == 2'd2) begin
      dstSkip  = skipQ;
      bitSkip  = quot[2:0];
      byteSkip = quot[3];
    end else begin
      bitSkip  = skipQ[2:0];
      byteSkip = 1'b0;
      dstSkip  = 5'(bitSkip * bpp);
    end
  end

  logic [X_W-1:0] xNext;
  assign xNext     = xPos + X_W'(bpp);
  assign linesDone = (lineCnt == heightQ);
  assign lineEmpty = (X_W'(dstSkip) >= X_W'(widthQ));
  assign lastPix   = (xNext >= X_W'(widthQ));
  assign byteEnd   = (bitIdx == 3'd7);

  assign srcRdAddr = srcPtr;
  assign dstWrEn   = ctl.pixel & srcByte[3'd7 - bitIdx];
  assign dstWrAddr = lineDst + ADDR_W'(xPos);
  assign dstWrData = fgQ;
  assign dstWrBe   = beMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depthQ <= '0; widthQ <= '0; heightQ <= '0; lineCnt <= '0;
      srcPitchQ <= '0; dstPitchQ <= '0; lineSrc <= '0; lineDst <= '0;
      srcPtr <= '0; fgQ <= '0; invQ <= 1'b0; skipQ <= '0;
      xPos <= '0; bitIdx <= '0; srcByte <= '0;
    end else begin
      if (ctl.accept) begin
        depthQ    <= depthSel;
        widthQ    <= widthBytes;
        heightQ   <= heightLines;
        srcPitchQ <= srcPitch;
        dstPitchQ <= dstPitch;
        lineSrc   <= srcBase;
        lineDst   <= dstBase;
        fgQ       <= fgColor;
        invQ      <= invert;
        skipQ     <= skipField;
        lineCnt   <= '0;
      end
      if (ctl.lineInit) begin
        xPos   <= X_W'(dstSkip);
        srcPtr <= lineSrc + ADDR_W'(byteSkip);
        bitIdx <= bitSkip;
      end
      if (ctl.load) srcByte <= srcRdData ^ {8{invQ}};
      if (ctl.pixel) begin
        xPos   <= xNext;
        bitIdx <= bitIdx + 3'd1;
        if (byteEnd) srcPtr <= srcPtr + ADDR_W'(1);
      end
      if (ctl.advLine) begin
        lineSrc <= lineSrc + srcPitchQ;
        lineDst <= lineDst + dstPitchQ;
        lineCnt <= lineCnt + LINE_W'(1);
      end
    end
  end

  // R7: every write lies inside the line width
  a_r7_write_in_line: assert property (@(posedge clk) disable iff (!rstN)
    dstWrEn |-> (xPos < X_W'(widthQ)));
  // R6: byte enables are contiguous from lane 0 and cover one pixel
  a_r6_be_pixel: assert property (@(posedge clk) disable iff (!rstN)
    dstWrEn |-> (dstWrBe[0] && $countones(dstWrBe) == int'(bpp)));
  // R9: captured configuration holds while a copy runs
  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(widthQ) && $stable(depthQ) && $stable(skipQ) && $stable(heightQ)));
  // R7: line count never exceeds the requested height
  a_r7_line_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (lineCnt <= heightQ));
endmodule

// File: rtl/blit_control.sv
module blit_control
  import blit_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     linesDone,
  input  logic     lineEmpty,
  input  logic     lastPix,
  input  logic     byteEnd,
  output blitCtl_t ctl,
  output logic     srcRdEn,
  output logic     busy,
  output logic     done
);
  blitState_t state, stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.accept = 1'b1;
        stateNext  = ST_LINE;
      end
      ST_LINE: begin
        if (linesDone) begin
          stateNext = ST_DONE;
        end else if (lineEmpty) begin
          ctl.advLine = 1'b1;
        end else begin
          ctl.lineInit = 1'b1;
          stateNext    = ST_FETCH;
        end
      end
      ST_FETCH: begin
        ctl.fetch = 1'b1;
        stateNext = ST_LOAD;
      end
      ST_LOAD: begin
        ctl.load  = 1'b1;
        stateNext = ST_PIX;
      end
      ST_PIX: begin
        ctl.pixel = 1'b1;
        if (lastPix) begin
          ctl.advLine = 1'b1;
          stateNext   = ST_LINE;
        end else if (byteEnd) begin
          stateNext = ST_FETCH;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign srcRdEn = ctl.fetch;
  assign busy    = (state != ST_IDLE) && (state != ST_DONE);
  assign done    = (state == ST_DONE);

  // R8: done is a single-cycle pulse with busy low
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));
  // R4: a read request is never repeated on the next cycle
  a_r4_read_spaced: assert property (@(posedge clk) disable iff (!rstN)
    srcRdEn |=> !srcRdEn);
endmodule

// File: rtl/mono_expand_blitter.sv
module mono_expand_blitter
  import blit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 12,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        depthSel,
  input  logic [DIM_W-1:0]  widthBytes,
  input  logic [LINE_W-1:0] heightLines,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] srcPitch,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [ADDR_W-1:0] dstPitch,
  input  logic [31:0]       fgColor,
  input  logic              invert,
  input  logic [4:0]        skipField,
  output logic              srcRdEn,
  output logic [ADDR_W-1:0] srcRdAddr,
  input  logic [7:0]        srcRdData,
  output logic              dstWrEn,
  output logic [ADDR_W-1:0] dstWrAddr,
  output logic [31:0]       dstWrData,
  output logic [3:0]        dstWrBe,
  output logic              busy,
  output logic              done
);
  blitCtl_t ctl;
  logic linesDone, lineEmpty, lastPix, byteEnd;

  blit_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .linesDone(linesDone), .lineEmpty(lineEmpty),
    .lastPix(lastPix), .byteEnd(byteEnd),
    .ctl(ctl), .srcRdEn(srcRdEn), .busy(busy), .done(done)
  );

  blit_datapath #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .LINE_W(LINE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busy(busy),
    .depthSel(depthSel), .widthBytes(widthBytes), .heightLines(heightLines),
    .srcBase(srcBase), .srcPitch(srcPitch), .dstBase(dstBase), .dstPitch(dstPitch),
    .fgColor(fgColor), .invert(invert), .skipField(skipField),
    .srcRdAddr(srcRdAddr), .srcRdData(srcRdData),
    .dstWrEn(dstWrEn), .dstWrAddr(dstWrAddr), .dstWrData(dstWrData), .dstWrBe(dstWrBe),
    .linesDone(linesDone), .lineEmpty(lineEmpty), .lastPix(lastPix), .byteEnd(byteEnd)
  );

  // R1: no activity on the memory ports while idle
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy) |-> (!srcRdEn && !dstWrEn));
endmodule

// File: tb/tb_mono_expand_blitter.sv
module tb_mono_expand_blitter;
  localparam int ADDR_W = 16, DIM_W = 12, LINE_W = 10;
  localparam int MEM = 1024;
  localparam int SRC_BASE = 16, SRC_PITCH = 8, DST_BASE = 256, DST_PITCH = 64;
  localparam logic [31:0] FG = 32'hC3B2A191;
  // vector: depth(2) width(8) height(4) skip(5) invert(1)
  localparam int NV = 8;
  localparam logic [19:0] VECS [0:NV-1] = '{
    {2'd0, 8'd20, 4'd3, 5'd0,  1'b0},
    {2'd1, 8'd24, 4'd2, 5'd5,  1'b0},
    {2'd3, 8'd40, 4'd2, 5'd3,  1'b1},
    {2'd2, 8'd48, 4'd2, 5'd31, 1'b0},
    {2'd2, 8'd30, 4'd3, 5'd7,  1'b1},
    {2'd0, 8'd17, 4'd2, 5'd27, 1'b0},
    {2'd2, 8'd36, 4'd1, 5'd24, 1'b0},
    {2'd1, 8'd9,  4'd2, 5'd0,  1'b1}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [1:0] depthSel = '0;
  logic [DIM_W-1:0] widthBytes = '0;
  logic [LINE_W-1:0] heightLines = '0;
  logic [ADDR_W-1:0] srcBase = ADDR_W'(SRC_BASE), srcPitch = ADDR_W'(SRC_PITCH);
  logic [ADDR_W-1:0] dstBase = ADDR_W'(DST_BASE), dstPitch = ADDR_W'(DST_PITCH);
  logic [31:0] fgColor = FG;
  logic invert = 1'b0;
  logic [4:0] skipField = '0;
  logic srcRdEn, dstWrEn, busy, done;
  logic [ADDR_W-1:0] srcRdAddr, dstWrAddr;
  logic [7:0] srcRdData = '0;
  logic [31:0] dstWrData;
  logic [3:0] dstWrBe;

  always #2 clk = ~clk;  // 250 MHz

  mono_expand_blitter #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .LINE_W(LINE_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .depthSel(depthSel),
    .widthBytes(widthBytes), .heightLines(heightLines),
    .srcBase(srcBase), .srcPitch(srcPitch), .dstBase(dstBase), .dstPitch(dstPitch),
    .fgColor(fgColor), .invert(invert), .skipField(skipField),
    .srcRdEn(srcRdEn), .srcRdAddr(srcRdAddr), .srcRdData(srcRdData),
    .dstWrEn(dstWrEn), .dstWrAddr(dstWrAddr), .dstWrData(dstWrData), .dstWrBe(dstWrBe),
    .busy(busy), .done(done)
  );

  logic [7:0] srcMem [0:MEM-1];
  logic [7:0] dstMem [0:MEM-1];
  logic [7:0] refMem [0:MEM-1];
  int wrCount = 0, expWrites = 0;
  int errors = 0, checks = 0, cycles = 0;

  // Memory models, serviced away from the active edge.
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (srcRdEn) srcRdData <= srcMem[int'(srcRdAddr) % MEM];
    if (dstWrEn) begin
      for (int k = 0; k < 4; k++)
        if (dstWrBe[k]) dstMem[(int'(dstWrAddr) + k) % MEM] = dstWrData[8*k +: 8];
      wrCount++;
    end
  end

  always @(negedge clk) if (cycles > 150000) begin
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearDst();
    for (int i = 0; i < MEM; i++) begin dstMem[i] = 8'hA5; refMem[i] = 8'hA5; end
    wrCount = 0; expWrites = 0;
  endtask

  // Independent reference from the requirements.
  task automatic model(input int d, input int w, input int h, input int sk, input bit inv);
    int bpp, ds, bb, bi, q;
    bpp = d + 1;
    if (d == 2) begin ds = sk; q = sk / 3; bb = q >> 3; bi = q & 7; end
    else begin bi = sk & 7; bb = 0; ds = bi * bpp; end
    for (int y = 0; y < h; y++)
      for (int x = ds; x < w; x += bpp) begin
        int pos; logic [7:0] b;
        pos = bb * 8 + bi + (x - ds) / bpp;
        b = srcMem[(SRC_BASE + y * SRC_PITCH + pos / 8) % MEM] ^ (inv ? 8'hFF : 8'h00);
        if (b[7 - pos % 8]) begin
          for (int k = 0; k < bpp; k++)
            refMem[(DST_BASE + y * DST_PITCH + x + k) % MEM] = FG[8*k +: 8];
          expWrites++;
        end
      end
  endtask

  task automatic drive(input int d, input int w, input int h, input int sk, input bit inv);
    depthSel = 2'(d); widthBytes = DIM_W'(w); heightLines = LINE_W'(h);
    skipField = 5'(sk); invert = inv;
  endtask

  // Returns after the done pulse; checks pulse shape (R8).
  task automatic waitDone(input string tag);
    int t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    check({tag, " R8 done seen"}, int'(done), 1);
    check({tag, " R8 busy low at done"}, int'(busy), 0);
    @(negedge clk);
    check({tag, " R8 done one cycle"}, int'(done), 0);
  endtask

  task automatic pulseStart();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  function automatic int memDiffs();
    int n = 0;
    for (int i = 0; i < MEM; i++) if (dstMem[i] !== refMem[i]) n++;
    return n;
  endfunction

  initial begin
    for (int i = 0; i < MEM; i++) srcMem[i] = 8'((i * 29 + 7) ^ (i >> 3));
    clearDst();
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 srcRdEn", int'(srcRdEn), 0);
    check("R1 dstWrEn", int'(dstWrEn), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: R2 (depths 0/1/3, upper skip bits), R3 (24 bpp skips),
    // R4/R5/R6/R7 via full destination compare.
    for (int v = 0; v < NV; v++) begin
      int d, w, h, sk; bit inv; string tag;
      {d, w, h, sk, inv} = {30'(VECS[v][19:18]), 32'(VECS[v][17:10]),
                            32'(VECS[v][9:6]), 32'(VECS[v][5:1]), VECS[v][0]};
      tag = $sformatf("vec%0d", v);
      clearDst();
      model(d, w, h, sk, inv);
      drive(d, w, h, sk, inv);
      pulseStart();
      check({tag, " R8 busy after start"}, int'(busy), 1);
      waitDone(tag);
      check({tag, " R6 R7 write count"}, wrCount, expWrites);
      check({tag, " R2 R3 R4 R5 mem mismatches"}, memDiffs(), 0);
    end

    // R8: zero height finishes without writes
    clearDst();
    drive(0, 20, 0, 0, 0);
    pulseStart();
    waitDone("h0");
    check("R8 zero height writes", wrCount, 0);

    // R7: skip at or beyond width gives no writes on any line
    clearDst();
    drive(0, 5, 3, 7, 1);
    pulseStart();
    waitDone("empty");
    check("R7 empty line writes", wrCount, 0);

    // R9: mid-copy start with new settings is ignored
    clearDst();
    model(2, 48, 2, 31, 0);
    drive(2, 48, 2, 31, 0);
    pulseStart();
    repeat (5) @(negedge clk);
    drive(3, 40, 3, 0, 1);
    pulseStart();
    drive(0, 8, 1, 0, 0);
    waitDone("busy-start");
    check("R9 write count", wrCount, expWrites);
    check("R9 mem mismatches", memDiffs(), 0);
    // R9: no new copy begins after completion without a fresh start
    repeat (3) @(negedge clk);
    check("R9 stays idle", int'(busy), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule